// File: doc/BRIEF.md
# Single-Wire Debug Acknowledge Pulse Generator

This block lives on the target side of a single-wire, open-drain background debug link. Some host commands need the CPU to run them. For those commands the block tells the host when execution has really finished. The serial receiver gives it a one-cycle strobe when a command ends. That strobe is asserted in the 16th debug-clock cycle of the command's last bit. The CPU side raises a completion level in its own, possibly much slower, clock domain. The block synchronizes that level, and a stop-mode level, into the debug clock domain itself.

Once a command has ended, the block waits at least a fixed number of debug-clock cycles, and for as long as the completion takes beyond that. It then drives the pin low for a fixed number of cycles. Next it drives the pin high for one cycle to speed up the pull-up edge. Finally it releases the pin to high impedance, and for that one cycle it flags to the host interface that the next bit may follow.

If the core enters stop mode before the command has run, the command is dropped. No pulse is produced, and a sticky status code reports the drop until a later command completes. A handshake-enable input switches the whole pin path on or off. A command strobe that arrives while an acknowledge is still in progress is ignored and recorded in a sticky overrun flag.

Top module: `dbg_ack_pulser`

## Requirements
- R1: After reset, pin_oe, pin_out, ack_done and overrun are 0 and status is 3'b000.
- R2: The low phase drives pin_oe=1 with pin_out=0 for exactly LOW_CYC (16) consecutive clock cycles.
- R3: The low phase is followed directly by exactly one cycle with pin_oe=1 and pin_out=1. pin_oe is 0 in every other cycle.
- R4: If the completion is already known, the first low cycle comes exactly MIN_GAP (32) cycles after the cycle in which cmd_end was sampled high, and never earlier.
- R5: There is no upper bound on the wait. When core_done rises after the minimum delay, pin_oe goes high after the third rising clock edge that follows the rise of core_done (two synchronizer flops plus the state register).
- R6: A rising core_stop that is synchronized while a command is pending and not yet completed drops the command. No low phase and no ack_done follow, and the block returns to idle. This applies both within and after the minimum delay.
- R7: status encodes 3'b000 = last command completed and 3'b001 = last command dropped by stop mode. 3'b001 stays until a later synchronized completion, which sets 3'b000. A new pending command alone does not clear it.
- R8: ack_done is 1 for exactly one cycle, the cycle right after the speedup cycle, with pin_oe=0.
- R9: When hs_en is 0 in the cmd_end cycle, the command is not tracked. A following completion causes no pin drive and no ack_done, but it still sets status to 3'b000.
- R10: A cmd_end while a command is pending or being acknowledged is ignored, so the pulse timing still follows the first command. It sets overrun to 1 until reset.
- R11: If the completion and stop events are synchronized in the same cycle, or the completion was already latched when the stop arrives, the completion wins: the pulse is produced and status is 3'b000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Debug clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_en | input | 1 | Handshake enable, sampled with cmd_end |
| cmd_end | input | 1 | One-cycle strobe in the 16th cycle of the last command bit |
| core_done | input | 1 | Completion level from the core clock domain |
| core_stop | input | 1 | Stop-mode level from the core clock domain |
| pin_oe | output | 1 | Pin drive enable (0 = high impedance) |
| pin_out | output | 1 | Pin value while driven |
| ack_done | output | 1 | One-cycle flag when the pin is released after an acknowledge |
| status | output | 3 | Completion status code |
| overrun | output | 1 | Sticky flag for a command strobe that was ignored |

## Verification
A wrong sequencer state shows up at pin_oe and pin_out in the same cycle it appears, because both are decoded straight from the state register. A counter that is off by one shows up as a low phase of the wrong length, or a start that is shifted from the 32-cycle mark, within one acknowledge. The bench compares the pins, ack_done, status and overrun against an independent behavioural model on every clock, so any divergence is reported in the cycle it first occurs. Directed measurements of the delay from command end, the delay from completion, and the phase lengths then name the timing requirement that broke.

// File: rtl/dbg_ack_pkg.sv
package dbg_ack_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WAIT_MIN  = 3'd1,
        ST_WAIT_DONE = 3'd2,
        ST_ACK_LOW   = 3'd3,
        ST_SPEEDUP   = 3'd4,
        ST_RELEASE   = 3'd5
    } ack_state_e;

    localparam logic [2:0] STAT_OK      = 3'b000;
    localparam logic [2:0] STAT_DROPPED = 3'b001;

endpackage

// File: rtl/dbg_ack_sync.sv
module dbg_ack_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] rise
);
    // chain[0..STAGES-1] are the synchronizer flops, chain[STAGES] keeps history for edge detection
    logic [STAGES:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int i = 1; i <= STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

    // R5: a synchronized edge event lasts a single cycle
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((rise & $past(rise)) == '0));

endmodule

// File: rtl/dbg_ack_seq.sv
module dbg_ack_seq
    import dbg_ack_pkg::*;
#(
    parameter int MIN_GAP = 32,
    parameter int LOW_CYC = 16,
    parameter int SPD_CYC = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hs_en,
    input  logic       cmd_end,
    input  logic       done_evt,
    input  logic       stop_evt,
    output ack_state_e state,
    output logic [2:0] status,
    output logic       overrun
);
    localparam int MAXC  = (MIN_GAP > LOW_CYC) ? ((MIN_GAP > SPD_CYC) ? MIN_GAP : SPD_CYC)
                                               : ((LOW_CYC > SPD_CYC) ? LOW_CYC : SPD_CYC);
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(MIN_GAP - 2);
    localparam logic [CNT_W-1:0] LOW_LAST = CNT_W'(LOW_CYC - 1);
    localparam logic [CNT_W-1:0] SPD_LAST = CNT_W'(SPD_CYC - 1);

    typedef struct packed {
        ack_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             seen;
        logic [2:0]       status;
        logic             overrun;
    } seq_regs_t;

    seq_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (cur_q.state != ST_IDLE && cmd_end) nxt_d.overrun = 1'b1;
        case (cur_q.state)
            ST_IDLE: begin
                if (done_evt) nxt_d.status = STAT_OK;
                if (cmd_end && hs_en) begin
                    nxt_d.state = ST_WAIT_MIN;
                    nxt_d.cnt   = '0;
                    nxt_d.seen  = 1'b0;
                end
            end
            ST_WAIT_MIN: begin
                if (done_evt) begin
                    nxt_d.seen   = 1'b1;
                    nxt_d.status = STAT_OK;
                end
                if (stop_evt && !done_evt && !cur_q.seen) begin
                    nxt_d.state  = ST_IDLE;
                    nxt_d.status = STAT_DROPPED;
                end else if (cur_q.cnt == GAP_LAST) begin
                    nxt_d.cnt   = '0;
                    nxt_d.state = (cur_q.seen || done_evt) ? ST_ACK_LOW : ST_WAIT_DONE;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            ST_WAIT_DONE: begin
                if (done_evt) begin
                    nxt_d.state  = ST_ACK_LOW;
                    nxt_d.cnt    = '0;
                    nxt_d.status = STAT_OK;
                end else if (stop_evt) begin
                    nxt_d.state  = ST_IDLE;
                    nxt_d.status = STAT_DROPPED;
                end
            end
            ST_ACK_LOW: begin
                if (cur_q.cnt == LOW_LAST) begin
                    nxt_d.state = ST_SPEEDUP;
                    nxt_d.cnt   = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            ST_SPEEDUP: begin
                if (cur_q.cnt == SPD_LAST) begin
                    nxt_d.state = ST_RELEASE;
                    nxt_d.cnt   = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            ST_RELEASE: nxt_d.state = ST_IDLE;
            default:    nxt_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state   <= ST_IDLE;
            cur_q.cnt     <= '0;
            cur_q.seen    <= 1'b0;
            cur_q.status  <= STAT_OK;
            cur_q.overrun <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign state   = cur_q.state;
    assign status  = cur_q.status;
    assign overrun = cur_q.overrun;

    // R2
    low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_ACK_LOW && cur_q.cnt != LOW_LAST) |=> cur_q.state == ST_ACK_LOW);

    // R4
    min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_WAIT_MIN && cur_q.cnt != GAP_LAST && !stop_evt) |=> cur_q.state == ST_WAIT_MIN);

    // R6
    stop_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_WAIT_DONE && stop_evt && !done_evt)
        |=> (cur_q.state == ST_IDLE && cur_q.status == STAT_DROPPED));

    // R7
    sticky_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.status == STAT_DROPPED && !done_evt) |=> cur_q.status == STAT_DROPPED);

    // R8
    release_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.state == ST_RELEASE |=> cur_q.state == ST_IDLE);

    // R10
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state != ST_IDLE && cmd_end) |=> (cur_q.overrun && $stable(cur_q.state) || cur_q.overrun));

endmodule

// File: rtl/dbg_ack_drive.sv
module dbg_ack_drive
    import dbg_ack_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  ack_state_e state,
    output logic       pin_oe,
    output logic       pin_out,
    output logic       ack_done
);
    assign pin_oe   = (state == ST_ACK_LOW) || (state == ST_SPEEDUP);
    assign pin_out  = (state == ST_SPEEDUP);
    assign ack_done = (state == ST_RELEASE);

    // R3: the speedup drive is one cycle and is followed by release
    spd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe && pin_out) |=> (!pin_oe && ack_done));

    // R8: ack_done is a single-cycle flag
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_done |=> !ack_done);

endmodule

// File: rtl/dbg_ack_pulser.sv
module dbg_ack_pulser
    import dbg_ack_pkg::*;
#(
    parameter int MIN_GAP     = 32,
    parameter int LOW_CYC     = 16,
    parameter int SPD_CYC     = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hs_en,
    input  logic       cmd_end,
    input  logic       core_done,
    input  logic       core_stop,
    output logic       pin_oe,
    output logic       pin_out,
    output logic       ack_done,
    output logic [2:0] status,
    output logic       overrun
);
    logic [1:0] rise;
    ack_state_e state;

    dbg_ack_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({core_stop, core_done}),
        .rise     (rise)
    );

    dbg_ack_seq #(.MIN_GAP(MIN_GAP), .LOW_CYC(LOW_CYC), .SPD_CYC(SPD_CYC)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .hs_en    (hs_en),
        .cmd_end  (cmd_end),
        .done_evt (rise[0]),
        .stop_evt (rise[1]),
        .state    (state),
        .status   (status),
        .overrun  (overrun)
    );

    dbg_ack_drive u_drive (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .pin_oe   (pin_oe),
        .pin_out  (pin_out),
        .ack_done (ack_done)
    );

    // R9: with the handshake disabled an idle block never starts driving
    hs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_oe && !hs_en && !ack_done && state == ST_IDLE) |=> !pin_oe);

endmodule

// File: tb/dbg_ack_pulser_test.sv
module dbg_ack_pulser_test;
    localparam int CLK_PERIOD = 10;
    localparam int GAP = 32, LOWN = 16;
    localparam int M_IDLE = 0, M_WMIN = 1, M_WDONE = 2, M_LOW = 3, M_SPD = 4, M_REL = 5;

    logic clk = 0, rst_n = 0, hs_en = 1, cmd_end = 0, core_done = 0, core_stop = 0;
    logic pin_oe, pin_out, ack_done, overrun;
    logic [2:0] status;

    dbg_ack_pulser uut (.clk(clk), .rst_n(rst_n), .hs_en(hs_en), .cmd_end(cmd_end),
        .core_done(core_done), .core_stop(core_stop), .pin_oe(pin_oe), .pin_out(pin_out),
        .ack_done(ack_done), .status(status), .overrun(overrun));

    always #(CLK_PERIOD/2) clk = ~clk;

    int tests = 0, fails = 0, cyc = 0;
    bit finished = 0;

    // behavioural reference state
    int m_mode = M_IDLE, m_t = 0, m_stat = 0;
    bit m_seen = 0, m_ovr = 0;
    bit dq[$] = '{0, 0, 0};
    bit sq[$] = '{0, 0, 0};

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_mode = M_IDLE; m_t = 0; m_stat = 0; m_seen = 0; m_ovr = 0;
            dq = '{0, 0, 0}; sq = '{0, 0, 0};
        end else begin
            bit dev, sev;
            dev = dq[1] && !dq[2];
            sev = sq[1] && !sq[2];
            dq.push_front(core_done); void'(dq.pop_back());
            sq.push_front(core_stop); void'(sq.pop_back());
            if (m_mode != M_IDLE && cmd_end) m_ovr = 1;
            case (m_mode)
                M_IDLE: begin
                    if (dev) m_stat = 0;
                    if (cmd_end && hs_en) begin m_mode = M_WMIN; m_t = 0; m_seen = 0; end
                end
                M_WMIN: begin
                    if (dev) begin m_seen = 1; m_stat = 0; end
                    if (sev && !m_seen) begin m_mode = M_IDLE; m_stat = 1; end
                    else if (m_t == GAP - 2) begin m_t = 0; m_mode = m_seen ? M_LOW : M_WDONE; end
                    else m_t++;
                end
                M_WDONE: begin
                    if (dev) begin m_mode = M_LOW; m_t = 0; m_stat = 0; end
                    else if (sev) begin m_mode = M_IDLE; m_stat = 1; end
                end
                M_LOW: if (m_t == LOWN - 1) begin m_mode = M_SPD; m_t = 0; end else m_t++;
                M_SPD: m_mode = M_REL;
                default: m_mode = M_IDLE;
            endcase
        end
    end

    // measurements and per-cycle comparison
    int oe_start = -1, low_len = 0, spd_len = 0, ack_cnt = 0;
    bit prev_oe = 0;

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(negedge clk) if (rst_n) begin
        if (pin_oe && !prev_oe && oe_start < 0) oe_start = cyc;
        if (pin_oe && !pin_out) low_len++;
        if (pin_oe && pin_out) spd_len++;
        if (ack_done) ack_cnt++;
        prev_oe = pin_oe;
        tests++;
        if (pin_oe !== (m_mode == M_LOW || m_mode == M_SPD) || pin_out !== (m_mode == M_SPD)) begin
            fails++;
            $display("FAIL R3 model pin: actual oe=%0b out=%0b expected mode %0d (cycle %0d)", pin_oe, pin_out, m_mode, cyc);
        end else if (ack_done !== (m_mode == M_REL)) begin
            fails++;
            $display("FAIL R8 model ack_done: actual %0b expected %0b", ack_done, m_mode == M_REL);
        end else if (status !== 3'(m_stat)) begin
            fails++;
            $display("FAIL R7 model status: actual %0d expected %0d", status, m_stat);
        end else if (overrun !== m_ovr) begin
            fails++;
            $display("FAIL R10 model overrun: actual %0b expected %0b", overrun, m_ovr);
        end
    end

    task automatic clear_meas();
        oe_start = -1; low_len = 0; spd_len = 0; ack_cnt = 0;
    endtask
    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask
    int cmd_cyc = 0, done_cyc = 0;
    task automatic send_cmd();
        @(negedge clk); cmd_end = 1; cmd_cyc = cyc;
        @(negedge clk); cmd_end = 0;
    endtask
    task automatic pulse_done(int hold);
        @(negedge clk); core_done = 1; done_cyc = cyc;
        idle(hold); core_done = 0;
    endtask
    task automatic pulse_stop();
        @(negedge clk); core_stop = 1;
        idle(4); core_stop = 0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        idle(3);
        chk("R1 pin_oe", pin_oe, 0); chk("R1 pin_out", pin_out, 0);
        chk("R1 ack_done", ack_done, 0); chk("R1 status", status, 0); chk("R1 overrun", overrun, 0);
        rst_n = 1;
        idle(2);

        // early completion: start pinned to the minimum delay
        clear_meas(); send_cmd(); idle(2); pulse_done(4); idle(45);
        chk("R4 gap from cmd_end", oe_start - cmd_cyc, GAP);
        chk("R2 low length", low_len, LOWN);
        chk("R3 speedup length", spd_len, 1);
        chk("R8 ack_done count", ack_cnt, 1);

        // late completion: start follows the synchronized completion
        clear_meas(); send_cmd(); idle(100); pulse_done(3); idle(30);
        chk("R5 delay from core_done", oe_start - done_cyc, 3);
        chk("R2 low length late", low_len, LOWN);
        chk("R5 status ok", status, 0);

        // stop during minimum delay
        clear_meas(); send_cmd(); idle(8); pulse_stop(); idle(50);
        chk("R6 no pulse (min wait)", oe_start, -1);
        chk("R6 no ack", ack_cnt, 0);
        chk("R7 status dropped", status, 1);

        // pending command keeps dropped status until it completes
        clear_meas(); send_cmd(); idle(45);
        chk("R7 status held while pending", status, 1);
        pulse_done(3); idle(30);
        chk("R7 status cleared", status, 0);
        chk("R7 pulse after clear", ack_cnt, 1);

        // stop after minimum delay
        clear_meas(); send_cmd(); idle(50); pulse_stop(); idle(30);
        chk("R6 no pulse (open wait)", oe_start, -1);
        chk("R6 status dropped again", status, 1);

        // handshake disabled
        clear_meas(); hs_en = 0; send_cmd(); idle(2); pulse_done(3); idle(60);
        chk("R9 no pin drive", oe_start, -1);
        chk("R9 no ack_done", ack_cnt, 0);
        chk("R9 status set ok", status, 0);
        chk("R10 no overrun when disabled", overrun, 0);
        hs_en = 1;

        // overrun: second strobe ignored
        begin
            int first;
            clear_meas(); send_cmd(); first = cmd_cyc; idle(8); send_cmd();
            pulse_done(3); idle(45);
            chk("R10 timing follows first", oe_start - first, GAP);
            chk("R10 single pulse", ack_cnt, 1);
            chk("R10 overrun set", overrun, 1);
        end

        // completion and stop arriving together
        clear_meas(); send_cmd(); idle(50);
        @(negedge clk); core_done = 1; core_stop = 1; done_cyc = cyc;
        idle(4); core_done = 0; core_stop = 0; idle(30);
        chk("R11 pulse produced", ack_cnt, 1);
        chk("R11 status ok", status, 0);

        // completion latched early, stop later within minimum delay
        clear_meas(); send_cmd(); idle(1); pulse_done(3); idle(5); pulse_stop(); idle(45);
        chk("R11 latched completion wins", ack_cnt, 1);
        chk("R11 gap kept", oe_start - cmd_cyc, GAP);

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++; tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule